// File: doc/BRIEF.md
# Port Connection Manager

This block sits between an upper-layer requester and the link-layer confirmations of one port. It tracks a single connection attempt through three states. A request taken in the idle state starts an open attempt. The link then reports one outcome: success, a retry, or failure to connect. Once the connection is up, the block holds it until the link reports that it has closed. Every message it sends upward is a registered pulse that lasts one clock.

The block also handles link teardown. A phy-disabled indication ends any outstanding attempt or connection. A hard-reset-received indication terminates all operations in every state, and this includes the idle state. The idle case matters because teardown of the link always brings the machine back to idle before the reset primitive can be seen. If the idle state ignored the reset, the termination would never take place.

Top module: `port_conn_mgr`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows `conn_state` = 0 (idle) and all five message outputs low. The reset is synchronous and active low.
- R2: `conn_state` encodes idle as 0, request-wait as 1 and connected as 2, and it never takes the value 3.
- R3: In idle, `req_open` moves the block to request-wait and pulses `link_open_req` for one cycle, provided `hard_reset_rx` and `phy_down` are both low in that cycle. `req_open` in request-wait or connected changes nothing, and in those states `link_open_req` stays low.
- R4: In request-wait, the open outcomes are taken in the order `link_open_fail`, then `link_open_retry`, then `link_open_ok`. Fail returns to idle with a `msg_unable_conn` pulse. Retry returns to idle with a `msg_retry_open` pulse. Ok moves to connected and sends no message.
- R5: In connected, `link_closed` returns the block to idle with a `msg_conn_closed` pulse. `link_closed` has no effect in idle or request-wait.
- R6: `phy_down` in request-wait or connected returns the block to idle with an `ops_terminated` pulse. In idle, `phy_down` has no effect other than blocking a request in the same cycle.
- R7: `hard_reset_rx` in any state, idle included, gives idle and an `ops_terminated` pulse on the next cycle. This also holds after an earlier `phy_down` or `link_closed` has already returned the block to idle.
- R8: When inputs coincide, the priority is hard reset, then phy-disabled, then link closure, then the open outcome or request. At most one of the five message outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_open | input | 1 | Upper-layer connection request |
| link_open_ok | input | 1 | Link reports the connection is open |
| link_open_retry | input | 1 | Link asks for the open to be retried |
| link_open_fail | input | 1 | Link reports it could not connect |
| link_closed | input | 1 | Link reports the connection closed |
| phy_down | input | 1 | Phy-disabled confirmation |
| hard_reset_rx | input | 1 | Hard-reset-received confirmation |
| conn_state | output | 2 | Current state (0 idle, 1 request-wait, 2 connected) |
| link_open_req | output | 1 | One-cycle pulse: request accepted, open attempt started |
| msg_retry_open | output | 1 | One-cycle retry-open message |
| msg_unable_conn | output | 1 | One-cycle unable-to-connect message |
| msg_conn_closed | output | 1 | One-cycle connection-closed message |
| ops_terminated | output | 1 | One-cycle pulse: all operations terminated |

## Verification
Termination and a normal outcome can land in the same cycle. Examples are a hard reset or phy-disabled arriving together with an open result, a closure or a new request. The bench forces these pairings directly and also through dense random stimulus in which several confirmations are often high together. It judges each cycle by checking that only the higher-priority result appears: one `ops_terminated` pulse, a return to idle, and no open, retry, unable or closed message alongside it.

// File: rtl/port_conn_mgr_pkg.sv
// Package: shared state encoding, event codes and message bundle for the
// port connection manager. Assumes a single outstanding connection.
package port_conn_mgr_pkg;

    localparam int STATE_W = 2;
    localparam int EVENT_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE      = 2'd0,
        ST_REQ_WAIT  = 2'd1,
        ST_CONNECTED = 2'd2
    } cm_state_e;

    typedef enum logic [EVENT_W-1:0] {
        EV_NONE       = 3'd0,
        EV_HARD_RESET = 3'd1,
        EV_PHY_DOWN   = 3'd2,
        EV_CLOSED     = 3'd3,
        EV_OPEN_FAIL  = 3'd4,
        EV_OPEN_RETRY = 3'd5,
        EV_OPEN_OK    = 3'd6,
        EV_REQUEST    = 3'd7
    } cm_event_e;

    typedef struct packed {
        logic retry;
        logic unable;
        logic closed;
        logic term;
        logic open_req;
    } cm_msg_t;

    localparam int MSG_W = $bits(cm_msg_t);

endpackage

// File: rtl/cm_event_arb.sv
// Module: cm_event_arb
// Reduces the confirmations of one cycle to a single event using a fixed
// priority: hard reset, phy down, closure, then open outcome or request.
// Assumes the inputs are synchronous to clk. The parameter TERM_IN_IDLE picks
// whether a hard reset seen in idle still terminates operations.
module cm_event_arb
    import port_conn_mgr_pkg::*;
#(
    parameter bit TERM_IN_IDLE = 1'b1
) (
    input  cm_state_e state,
    input  logic      req_open,
    input  logic      open_ok,
    input  logic      open_retry,
    input  logic      open_fail,
    input  logic      closed,
    input  logic      phy_down,
    input  logic      hard_reset,
    output cm_event_e event_o
);

    logic hr_effective;

    // Variant select: does a hard reset count while idle
    generate
        if (TERM_IN_IDLE) begin : g_hr_any
            assign hr_effective = hard_reset;
        end else begin : g_hr_busy
            assign hr_effective = hard_reset && (state != ST_IDLE);
        end
    endgenerate

    // Priority encode of this cycle's confirmations
    always_comb begin
        event_o = EV_NONE;
        if (hr_effective) begin
            event_o = EV_HARD_RESET;
        end else if (phy_down && state != ST_IDLE) begin
            event_o = EV_PHY_DOWN;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_open && !phy_down && !hard_reset) event_o = EV_REQUEST;
                end
                ST_REQ_WAIT: begin
                    if (open_fail)       event_o = EV_OPEN_FAIL;
                    else if (open_retry) event_o = EV_OPEN_RETRY;
                    else if (open_ok)    event_o = EV_OPEN_OK;
                end
                ST_CONNECTED: begin
                    if (closed) event_o = EV_CLOSED;
                end
                default: event_o = EV_NONE;
            endcase
        end
    end

endmodule

// File: rtl/cm_next_logic.sv
// Module: cm_next_logic
// Maps the current state and the selected event to the next state and the
// message to send. Purely combinational; the registers live elsewhere.
module cm_next_logic
    import port_conn_mgr_pkg::*;
(
    input  cm_state_e state,
    input  cm_event_e event_i,
    output cm_state_e state_nxt,
    output cm_msg_t   msg_nxt
);

    // Transition and message table
    always_comb begin
        state_nxt = state;
        msg_nxt   = '0;
        unique case (event_i)
            EV_HARD_RESET, EV_PHY_DOWN: begin
                state_nxt    = ST_IDLE;
                msg_nxt.term = 1'b1;
            end
            EV_CLOSED: begin
                state_nxt      = ST_IDLE;
                msg_nxt.closed = 1'b1;
            end
            EV_OPEN_FAIL: begin
                state_nxt      = ST_IDLE;
                msg_nxt.unable = 1'b1;
            end
            EV_OPEN_RETRY: begin
                state_nxt     = ST_IDLE;
                msg_nxt.retry = 1'b1;
            end
            EV_OPEN_OK: begin
                state_nxt = ST_CONNECTED;
            end
            EV_REQUEST: begin
                state_nxt        = ST_REQ_WAIT;
                msg_nxt.open_req = 1'b1;
            end
            default: begin
                state_nxt = state;
            end
        endcase
    end

endmodule

// File: rtl/cm_out_regs.sv
// Module: cm_out_regs
// Holds the state and the registered one-cycle messages. Synchronous
// active-low reset clears everything to idle.
module cm_out_regs
    import port_conn_mgr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cm_state_e state_nxt,
    input  cm_msg_t   msg_nxt,
    output cm_state_e state_q,
    output cm_msg_t   msg_q
);

    // State and message registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            msg_q   <= '0;
        end else begin
            state_q <= state_nxt;
            msg_q   <= msg_nxt;
        end
    end

endmodule

// File: rtl/port_conn_mgr.sv
// Module: port_conn_mgr (top)
// Connection manager for one port. It accepts an upper-layer request, waits
// for the link outcome, holds the connection until closure, and terminates
// operations on phy-disabled or hard-reset confirmations. A hard reset in
// idle still terminates, since teardown reaches idle before the reset shows.
// Assumes all inputs are synchronous to clk.
module port_conn_mgr
    import port_conn_mgr_pkg::*;
#(
    parameter bit TERM_IN_IDLE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_open,
    input  logic               link_open_ok,
    input  logic               link_open_retry,
    input  logic               link_open_fail,
    input  logic               link_closed,
    input  logic               phy_down,
    input  logic               hard_reset_rx,
    output logic [STATE_W-1:0] conn_state,
    output logic               link_open_req,
    output logic               msg_retry_open,
    output logic               msg_unable_conn,
    output logic               msg_conn_closed,
    output logic               ops_terminated
);

    cm_state_e state_q;
    cm_state_e state_nxt;
    cm_event_e event_sel;
    cm_msg_t   msg_nxt;
    cm_msg_t   msg_q;

    cm_event_arb #(
        .TERM_IN_IDLE(TERM_IN_IDLE)
    ) u_arb (
        .state      (state_q),
        .req_open   (req_open),
        .open_ok    (link_open_ok),
        .open_retry (link_open_retry),
        .open_fail  (link_open_fail),
        .closed     (link_closed),
        .phy_down   (phy_down),
        .hard_reset (hard_reset_rx),
        .event_o    (event_sel)
    );

    cm_next_logic u_next (
        .state     (state_q),
        .event_i   (event_sel),
        .state_nxt (state_nxt),
        .msg_nxt   (msg_nxt)
    );

    cm_out_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_nxt (state_nxt),
        .msg_nxt   (msg_nxt),
        .state_q   (state_q),
        .msg_q     (msg_q)
    );

    // Output mapping
    assign conn_state      = state_q;
    assign link_open_req   = msg_q.open_req;
    assign msg_retry_open  = msg_q.retry;
    assign msg_unable_conn = msg_q.unable;
    assign msg_conn_closed = msg_q.closed;
    assign ops_terminated  = msg_q.term;

endmodule

// File: rtl/cm_checker.sv
// Module: cm_checker
// Temporal checks on the port connection manager, attached by bind.
module cm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_open,
    input logic       link_open_ok,
    input logic       link_open_retry,
    input logic       link_open_fail,
    input logic       link_closed,
    input logic       phy_down,
    input logic       hard_reset_rx,
    input logic [1:0] conn_state,
    input logic       link_open_req,
    input logic       msg_retry_open,
    input logic       msg_unable_conn,
    input logic       msg_conn_closed,
    input logic       ops_terminated
);

    logic [4:0] msgs;
    assign msgs = {link_open_req, msg_retry_open, msg_unable_conn, msg_conn_closed, ops_terminated};

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (conn_state == 2'd0 && msgs == 5'd0));

    // R2
    state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conn_state != 2'd3);

    // R3
    req_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_state != 2'd0) |=> !link_open_req);

    // R4
    open_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_state == 2'd1 && link_open_fail && !phy_down && !hard_reset_rx)
        |=> (msg_unable_conn && conn_state == 2'd0));

    // R5
    close_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_state == 2'd2 && link_closed && !phy_down && !hard_reset_rx)
        |=> (msg_conn_closed && conn_state == 2'd0));

    // R6
    phy_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_state != 2'd0 && phy_down && !hard_reset_rx)
        |=> (ops_terminated && conn_state == 2'd0));

    // R7
    hard_reset_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hard_reset_rx |=> (ops_terminated && conn_state == 2'd0));

    // R8
    single_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(msgs));

endmodule

bind port_conn_mgr cm_checker u_cm_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_open        (req_open),
    .link_open_ok    (link_open_ok),
    .link_open_retry (link_open_retry),
    .link_open_fail  (link_open_fail),
    .link_closed     (link_closed),
    .phy_down        (phy_down),
    .hard_reset_rx   (hard_reset_rx),
    .conn_state      (conn_state),
    .link_open_req   (link_open_req),
    .msg_retry_open  (msg_retry_open),
    .msg_unable_conn (msg_unable_conn),
    .msg_conn_closed (msg_conn_closed),
    .ops_terminated  (ops_terminated)
);

// File: tb/tb_port_conn_mgr.sv
// Bench for port_conn_mgr: directed corner cases then seeded random stimulus,
// compared each cycle against a bench reference model.
module tb_port_conn_mgr;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_open = 1'b0, link_open_ok = 1'b0, link_open_retry = 1'b0;
    logic       link_open_fail = 1'b0, link_closed = 1'b0, phy_down = 1'b0, hard_reset_rx = 1'b0;
    logic [1:0] conn_state;
    logic       link_open_req, msg_retry_open, msg_unable_conn, msg_conn_closed, ops_terminated;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [1:0] mstate = 2'd0;
    logic [6:0] exp_out = 7'd0;
    string      exp_tag = "R1";
    bit         exp_valid = 1'b0;

    always #2 clk = ~clk;

    port_conn_mgr dut (
        .clk(clk), .rst_n(rst_n), .req_open(req_open),
        .link_open_ok(link_open_ok), .link_open_retry(link_open_retry),
        .link_open_fail(link_open_fail), .link_closed(link_closed),
        .phy_down(phy_down), .hard_reset_rx(hard_reset_rx),
        .conn_state(conn_state), .link_open_req(link_open_req),
        .msg_retry_open(msg_retry_open), .msg_unable_conn(msg_unable_conn),
        .msg_conn_closed(msg_conn_closed), .ops_terminated(ops_terminated)
    );

    // Reference: v = {req, ok, retry, fail, closed, phy, hrst};
    // result = {state[1:0], retry, unable, closed, term, open_req}
    function automatic logic [6:0] model(input logic [1:0] st, input logic [6:0] v);
        logic hr = v[0], pd = v[1], cl = v[2], fl = v[3], rt = v[4], ok = v[5], rq = v[6];
        if (hr) return {2'd0, 5'b00010};
        if (pd && st != 2'd0) return {2'd0, 5'b00010};
        case (st)
            2'd0: return (rq && !pd) ? {2'd1, 5'b00001} : {2'd0, 5'b00000};
            2'd1: begin
                if (fl) return {2'd0, 5'b01000};
                if (rt) return {2'd0, 5'b10000};
                if (ok) return {2'd2, 5'b00000};
                return {2'd1, 5'b00000};
            end
            default: return cl ? {2'd0, 5'b00100} : {2'd2, 5'b00000};
        endcase
    endfunction

    // Which requirement a cycle's result belongs to
    function automatic string tag_of(input logic [1:0] st, input logic [6:0] v);
        if ($countones(v) > 1) return "R8";
        if (v[0]) return "R7";
        if (v[1]) return "R6";
        if (v[2]) return "R5";
        if (v[5:3] != 3'd0) return "R4";
        return "R3";
    endfunction

    // Compare outputs to the value expected from the previous edge
    task automatic check_now();
        logic [6:0] act;
        act = {conn_state, msg_retry_open, msg_unable_conn, msg_conn_closed, ops_terminated, link_open_req};
        checks++;
        if (act !== exp_out) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", exp_tag, act, exp_out);
        end
        checks++;
        if (conn_state === 2'd3) begin
            failures++;
            $display("FAIL R2: actual state=%0d expected 0..2", conn_state);
        end
    endtask

    // One cycle: check the last result, then drive new inputs
    task automatic cyc(input logic rst_v, input logic [6:0] v);
        @(negedge clk);
        if (exp_valid) check_now();
        if (!rst_v) begin
            exp_out = 7'd0;
            exp_tag = "R1";
            mstate  = 2'd0;
        end else begin
            exp_out = model(mstate, v);
            exp_tag = tag_of(mstate, v);
            mstate  = exp_out[6:5];
        end
        exp_valid = 1'b1;
        rst_n = rst_v;
        {req_open, link_open_ok, link_open_retry, link_open_fail, link_closed, phy_down, hard_reset_rx} = v;
    endtask

    localparam logic [6:0] NONE = 7'b0000000, HR = 7'b0000001, PD = 7'b0000010,
                           CL = 7'b0000100, FL = 7'b0001000, RT = 7'b0010000,
                           OK = 7'b0100000, RQ = 7'b1000000;

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        // R1 reset
        cyc(1'b0, NONE); cyc(1'b0, RQ | OK); cyc(1'b1, NONE);
        // R3, R4, R5: request, open ok, request ignored while connected, close
        cyc(1'b1, RQ); cyc(1'b1, CL); cyc(1'b1, RQ | 7'b0);
        cyc(1'b1, OK); cyc(1'b1, RQ); cyc(1'b1, CL); cyc(1'b1, NONE);
        // R4 retry and fail, and fail beating retry (R8)
        cyc(1'b1, RQ); cyc(1'b1, RT); cyc(1'b1, RQ); cyc(1'b1, FL);
        cyc(1'b1, RQ); cyc(1'b1, FL | RT | OK);
        // R6 phy down in idle is ignored, blocks request; in connected terminates
        cyc(1'b1, PD); cyc(1'b1, PD | RQ); cyc(1'b1, NONE);
        cyc(1'b1, RQ); cyc(1'b1, OK); cyc(1'b1, PD);
        // R7 teardown order: phy down then closure then hard reset, all from idle
        cyc(1'b1, CL); cyc(1'b1, HR); cyc(1'b1, NONE);
        cyc(1'b1, RQ); cyc(1'b1, OK); cyc(1'b1, CL); cyc(1'b1, HR);
        // R8 coincidences: hard reset with phy down, closure, request, outcome
        cyc(1'b1, RQ); cyc(1'b1, HR | PD | OK);
        cyc(1'b1, RQ); cyc(1'b1, OK); cyc(1'b1, HR | CL);
        cyc(1'b1, RQ); cyc(1'b1, OK); cyc(1'b1, PD | CL);
        cyc(1'b1, HR | RQ); cyc(1'b1, RQ); cyc(1'b1, PD | RT);
        // Random phase with occasional reset
        for (int i = 0; i < 4000; i++) begin
            logic [6:0] v;
            for (int b = 0; b < 7; b++) v[b] = ($urandom % ((b < 2) ? 12 : 4)) == 0;
            cyc(($urandom % 200) != 0, v);
        end
        cyc(1'b1, NONE);
        cyc(1'b1, NONE);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule